// File: doc/BRIEF.md
# Missed Frame Counter with Overflow Interrupt

This block counts received frames that the host should have seen but that were lost. A frame is lost when it ends while the receiver cannot take it: receive is switched off, a receive FIFO overflow has not yet been cleared, or the FIFO already holds its full count of frames. Only frames that the receiver would normally hand to the host are counted. Such a frame passed address filtering, had no collision within the slot time, and was not a runt (unless the runt-accept test mode is on). Frames with CRC or framing errors are still counted, because they would normally reach the host.

The count is an 8-bit register that clears when the host reads it. When the count wraps past its maximum, a sticky overflow flag is set. The flag drives an interrupt output unless a mask bit blocks it. After any reset the counter stays dormant until receive has been enabled once. After that it counts every lost frame, whatever the enable later holds.

Top module: `missed_frame_counter`

## Requirements
- R1: After the asynchronous reset, or once a reset has been applied, the count reads 0, and the overflow flag, the mask and `irq` are all 0.
- R2: A frame is counted only in the cycle in which `eof` is 1 and at least one of these holds: `rx_enable` is 0, `fifo_ovf` is 1, or `frame_cnt_full` is 1. A qualifying frame that ends while the receiver can accept it leaves the count unchanged.
- R3: After any reset, no frame is counted until `rx_enable` has been sampled at 1 on some clock edge. A frame that ends on that same edge is not counted. Counting starts with the edge that follows.
- R4: Once `rx_enable` has been seen at 1, lost frames are counted whether `rx_enable` is 0 or 1.
- R5: A frame with `addr_match` at 0 is never counted.
- R6: A frame with `slot_collision` at 1 is never counted, even when runt-accept mode is on.
- R7: A frame with `runt` at 1 is counted only when `runt_accept` is 1.
- R8: A frame with `frame_err` at 1 that otherwise qualifies is counted.
- R9: `count` always shows the current value. A cycle with `rd_count` at 1 sets the count to 0 on the next edge. If a frame is counted in that same cycle, the count becomes 1 instead.
- R10: A counted frame while the count is 255 (with no read in that cycle) wraps the count to 0 and sets `ovf_flag`. The flag stays set until a cycle with `rd_status` at 1 clears it. If a new wrap occurs in the same cycle as that read, the flag stays set.
- R11: `irq` is 1 exactly when `ovf_flag` is 1 and `ovf_mask` is 0. The mask takes `mask_wdata` on an edge at which `mask_wr` is 1.
- R12: A cycle with `soft_rst` at 1 clears the count, the overflow flag and the mask. It also returns the counter to its dormant state, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset strobe |
| rx_enable | input | 1 | Receive-enable state |
| fifo_ovf | input | 1 | Receive FIFO overflow pending |
| frame_cnt_full | input | 1 | Receive FIFO frame count above its limit |
| eof | input | 1 | End-of-frame strobe; qualifiers are valid with it |
| addr_match | input | 1 | Frame passed address filtering |
| slot_collision | input | 1 | Collision seen within the slot time |
| runt | input | 1 | Frame shorter than the minimum length |
| runt_accept | input | 1 | Runt-accept test mode |
| frame_err | input | 1 | CRC or framing error on the frame |
| rd_count | input | 1 | Host read of the count (clears it) |
| rd_status | input | 1 | Host read of interrupt status (clears the flag) |
| mask_wr | input | 1 | Write strobe for the overflow mask |
| mask_wdata | input | 1 | Value for the overflow mask |
| count | output | 8 | Missed-frame count |
| ovf_flag | output | 1 | Sticky count-overflow flag |
| ovf_mask | output | 1 | Overflow interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers the arming edge in three ways:
- A frame lost in the very cycle receive is first enabled must not count. A design that armed combinationally would count it.
- Lost frames after receive is disabled again must still count. A design that gated counting on the live enable would miss them.
- After a soft reset the counter must be dormant again.

A frame with a collision in runt-accept mode and an errored frame are checked, to catch a qualification rule that was inverted or dropped.

A read that meets an increment must leave 1; a design that let the read win would leave 0. A wrap that meets a status read must leave the flag set; a design that let the read win would lose the overflow event. Masking must silence `irq` without clearing the flag.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  // Per-frame qualifiers, valid with the end-of-frame strobe
  typedef struct packed {
    logic addr_ok;
    logic collided;
    logic short_frm;
    logic short_ok;
    logic bad_crc;
  } frame_qual_t;

endpackage

// File: rtl/mfc_rst_sync.sv
// Asserts asynchronously, releases on the clock after SYNC_STAGES edges
module mfc_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [SYNC_STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[SYNC_STAGES-1];

endmodule

// File: rtl/mfc_qualify.sv
// Decides whether the frame ending this cycle is a counted miss; holds the arm state
module mfc_qualify
  import mfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        rx_enable,
  input  logic        fifo_ovf,
  input  logic        frame_cnt_full,
  input  logic        eof,
  input  frame_qual_t qual,
  output logic        count_evt
);

  logic armed_q, armed_d, armed_en;
  logic rx_blocked, deliverable;
  logic err_unused;

  // CRC/framing errors do not block delivery, so they play no part here
  assign err_unused = qual.bad_crc;

  always_comb begin
    rx_blocked  = !rx_enable || fifo_ovf || frame_cnt_full;
    deliverable = qual.addr_ok && !qual.collided && (!qual.short_frm || qual.short_ok);
    count_evt   = armed_q && eof && rx_blocked && deliverable && !soft_rst;
  end

  always_comb begin
    armed_en = soft_rst || (rx_enable && !armed_q);
    armed_d  = soft_rst ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

endmodule

// File: rtl/mfc_counter.sv
// Read-to-clear event counter with wrap detection
module mfc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    wrap   = 1'b0;
    cnt_en = soft_rst || rd_clr || inc;
    if (soft_rst) begin
      cnt_d = '0;
    end else if (rd_clr) begin
      cnt_d = inc ? CNT_ONE : '0;
    end else if (inc) begin
      cnt_d = cnt_q + CNT_ONE;
      wrap  = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/mfc_irq.sv
// Sticky overflow flag, mask bit and interrupt output
module mfc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic wrap,
  input  logic rd_status,
  input  logic mask_wr,
  input  logic mask_wdata,
  output logic flag,
  output logic mask,
  output logic irq
);

  logic flag_q, flag_d, flag_en;
  logic mask_q, mask_d, mask_en;

  always_comb begin
    flag_en = soft_rst || wrap || rd_status;
    flag_d  = !soft_rst && wrap;      // a new wrap outranks a status read
    mask_en = soft_rst || mask_wr;
    mask_d  = !soft_rst && mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign flag = flag_q;
  assign mask = mask_q;
  assign irq  = flag_q && !mask_q;

endmodule

// File: rtl/missed_frame_counter.sv
module missed_frame_counter
  import mfc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_enable,
  input  logic             fifo_ovf,
  input  logic             frame_cnt_full,
  input  logic             eof,
  input  logic             addr_match,
  input  logic             slot_collision,
  input  logic             runt,
  input  logic             runt_accept,
  input  logic             frame_err,
  input  logic             rd_count,
  input  logic             rd_status,
  input  logic             mask_wr,
  input  logic             mask_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             ovf_mask,
  output logic             irq
);

  logic        rst_n_int;
  logic        count_evt;
  logic        wrap_evt;
  frame_qual_t qual;

  assign qual = '{addr_ok:   addr_match,
                  collided:  slot_collision,
                  short_frm: runt,
                  short_ok:  runt_accept,
                  bad_crc:   frame_err};

  mfc_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mfc_qualify u_qualify (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .soft_rst       (soft_rst),
    .rx_enable      (rx_enable),
    .fifo_ovf       (fifo_ovf),
    .frame_cnt_full (frame_cnt_full),
    .eof            (eof),
    .qual           (qual),
    .count_evt      (count_evt)
  );

  mfc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .soft_rst (soft_rst),
    .inc      (count_evt),
    .rd_clr   (rd_count),
    .cnt      (count),
    .wrap     (wrap_evt)
  );

  mfc_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .soft_rst   (soft_rst),
    .wrap       (wrap_evt),
    .rd_status  (rd_status),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .flag       (ovf_flag),
    .mask       (ovf_mask),
    .irq        (irq)
  );

endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             rx_enable,
  input logic             eof,
  input logic             slot_collision,
  input logic             addr_match,
  input logic             rd_count,
  input logic             rd_status,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             ovf_mask,
  input logic             irq
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // Observer copy of "receive has been enabled since reset"
  logic seen_en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_en_q <= 1'b0;
    else if (soft_rst) seen_en_q <= 1'b0;
    else if (rx_enable) seen_en_q <= 1'b1;
  end

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && !ovf_mask));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count && !eof) |=> (count == '0));

  assert_hold_without_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eof && !rd_count && !soft_rst) |=> $stable(count));

  assert_dormant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_en_q && !rd_count && !soft_rst) |=> $stable(count));

  assert_collision_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && slot_collision && !rd_count && !soft_rst) |=> $stable(count));

  assert_no_match_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !addr_match && !rd_count && !soft_rst) |=> $stable(count));

  assert_wrap_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && !rd_count && !soft_rst) ##1 (count == '0) |-> ovf_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !rd_status && !soft_rst) |=> ovf_flag);

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count == '0 && !ovf_flag && !ovf_mask));

endmodule

bind missed_frame_counter mfc_checker #(.CNT_W(CNT_W)) u_mfc_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_rst       (soft_rst),
  .rx_enable      (rx_enable),
  .eof            (eof),
  .slot_collision (slot_collision),
  .addr_match     (addr_match),
  .rd_count       (rd_count),
  .rd_status      (rd_status),
  .count          (count),
  .ovf_flag       (ovf_flag),
  .ovf_mask       (ovf_mask),
  .irq            (irq)
);

// File: tb/missed_frame_counter_bench.sv
`timescale 1ns/1ps
module missed_frame_counter_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic soft_rst, rx_enable, fifo_ovf, frame_cnt_full, eof;
  logic addr_match, slot_collision, runt, runt_accept, frame_err;
  logic rd_count, rd_status, mask_wr, mask_wdata;
  logic [7:0] count;
  logic ovf_flag, ovf_mask, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt  = 0;

  always #5 clk = ~clk;

  missed_frame_counter u_missed_frame_counter (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_enable(rx_enable),
    .fifo_ovf(fifo_ovf), .frame_cnt_full(frame_cnt_full), .eof(eof),
    .addr_match(addr_match), .slot_collision(slot_collision), .runt(runt),
    .runt_accept(runt_accept), .frame_err(frame_err), .rd_count(rd_count),
    .rd_status(rd_status), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .count(count), .ovf_flag(ovf_flag), .ovf_mask(ovf_mask), .irq(irq)
  );

  // Vector bits: [8]=rx_enable [7]=fifo_ovf [6]=frame_cnt_full [5]=addr_match
  // [4]=slot_collision [3]=runt [2]=runt_accept [1]=frame_err [0]=expect counted
  localparam int NVEC = 12;
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_0_0_1_0_0_0_0_1,  // R4 disabled after arming -> counted
    9'b1_1_0_1_0_0_0_0_1,  // R2 FIFO overflow
    9'b1_0_1_1_0_0_0_0_1,  // R2 frame count full
    9'b1_0_0_1_0_0_0_0_0,  // R2 receiver able -> not counted
    9'b0_0_0_0_0_0_0_0_0,  // R5 no address match
    9'b1_1_0_1_1_0_0_0_0,  // R6 collision
    9'b0_0_0_1_0_1_0_0_0,  // R7 runt, accept off
    9'b0_0_0_1_0_1_1_0_1,  // R7 runt, accept on
    9'b0_1_1_1_0_0_0_1_1,  // R8 errored frame counted
    9'b1_0_0_1_0_0_0_1_0,  // R8 errored but delivered -> not a miss
    9'b0_0_0_1_1_1_1_0_0,  // R6 collision wins over runt accept
    9'b0_0_0_1_0_0_1_0_1   // R7 accept mode, normal frame
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    soft_rst = 0; rx_enable = 0; fifo_ovf = 0; frame_cnt_full = 0; eof = 0;
    addr_match = 0; slot_collision = 0; runt = 0; runt_accept = 0; frame_err = 0;
    rd_count = 0; rd_status = 0; mask_wr = 0; mask_wdata = 0;
  endtask

  // One lost, qualifying frame (receiver disabled), with optional reads alongside
  task automatic lost_frame(input logic with_rd, input logic with_status);
    rx_enable = 0; addr_match = 1; eof = 1; rd_count = with_rd; rd_status = with_status;
    @(negedge clk);
    eof = 0; rd_count = 0; rd_status = 0; addr_match = 0;
  endtask

  task automatic read_count();
    rd_count = 1; @(negedge clk); rd_count = 0;
  endtask

  initial begin : watchdog
    #1500000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 mask", ovf_mask, 0);
    chk("R1 irq", irq, 0);

    // R3 dormant before first enable
    lost_frame(0, 0);
    chk("R3 dormant", count, 0);
    // enable first seen on the same edge as a lost frame (FIFO overflow)
    rx_enable = 1; fifo_ovf = 1; addr_match = 1; eof = 1;
    @(negedge clk);
    eof = 0;
    chk("R3 arming edge", count, 0);
    eof = 1; @(negedge clk); eof = 0; fifo_ovf = 0; rx_enable = 0; addr_match = 0;
    chk("R3 armed", count, 1);
    read_count();
    chk("R9 read clear", count, 0);

    // Table walk: R2 R4 R5 R6 R7 R8
    exp_cnt = 0;
    for (int i = 0; i < NVEC; i++) begin
      {rx_enable, fifo_ovf, frame_cnt_full, addr_match, slot_collision,
       runt, runt_accept, frame_err} = VEC[i][8:1];
      eof = 1;
      @(negedge clk);
      idle_inputs();
      if (VEC[i][0]) exp_cnt++;
      chk($sformatf("R2/R4..R8 vector %0d", i), count, exp_cnt);
    end

    // R9 read meets increment -> 1
    lost_frame(1, 0);
    chk("R9 read with increment", count, 1);
    read_count();

    // R10 wrap and sticky flag
    for (int k = 0; k < 255; k++) lost_frame(0, 0);
    chk("R10 count at max", count, 255);
    chk("R10 no flag before wrap", ovf_flag, 0);
    lost_frame(0, 0);
    chk("R10 wrapped", count, 0);
    chk("R10 flag set", ovf_flag, 1);
    chk("R11 irq unmasked", irq, 1);
    lost_frame(0, 0);
    chk("R10 flag sticky", ovf_flag, 1);

    // R11 masking
    mask_wr = 1; mask_wdata = 1; @(negedge clk); mask_wr = 0; mask_wdata = 0;
    chk("R11 mask set", ovf_mask, 1);
    chk("R11 irq masked", irq, 0);
    chk("R11 flag kept under mask", ovf_flag, 1);
    mask_wr = 1; @(negedge clk); mask_wr = 0;
    chk("R11 irq unmasked again", irq, 1);

    rd_status = 1; @(negedge clk); rd_status = 0;
    chk("R10 status read clears", ovf_flag, 0);
    chk("R11 irq cleared", irq, 0);

    // R10 wrap in same cycle as status read: flag stays set
    for (int k = 0; k < 254; k++) lost_frame(0, 0);
    chk("R10 count at max again", count, 255);
    lost_frame(0, 1);
    chk("R10 wrap beats status read", ovf_flag, 1);

    // R12 soft reset
    mask_wr = 1; mask_wdata = 1; @(negedge clk); mask_wr = 0; mask_wdata = 0;
    lost_frame(0, 0);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk("R12 count", count, 0);
    chk("R12 flag", ovf_flag, 0);
    chk("R12 mask", ovf_mask, 0);
    lost_frame(0, 0);
    chk("R12 dormant again", count, 0);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule